// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

The block recovers characters from an asynchronous serial line. A sample-rate enable pulse, produced elsewhere, paces a per-bit sample counter that runs 16 samples per bit in normal mode or 8 in double-speed mode. A falling edge on a line that was seen high opens a candidate start bit. Three samples around the middle of that bit must vote low to accept it. Every later bit (data, optional parity, stop) is settled the same way, by a 2-of-3 vote over its three centre samples. This filters out short spikes and tolerates a few percent of bit-rate mismatch.

Finished characters enter a two-entry receive queue. Each entry carries its own framing and parity error flags. A third finished character waits in the shift stage until a read frees a slot. If a further start bit is accepted while the queue is full and a character is waiting, the waiting character is dropped and a sticky overrun flag is raised. The host sees the oldest character and its flags, pops it with a one-cycle read strobe, and may take an interrupt while unread data exist.

Top module: `uart_ovs_rx`

## Requirements
- R1: After reset, rx_valid_o, overrun_o and irq_o are 0.
- R2: The number of data bits is data_len_i. Values below 5 act as 5 and values above 9 act as 9. Data bits arrive LSB first, and rd_data_o bits at and above the data length read 0.
- R3: With dbl_speed_i=0 a bit lasts 16 sample enables. With dbl_speed_i=1 a bit lasts 8.
- R4: The first low sample after a high sample is sample 1 of a candidate start bit. The candidate is accepted only if at least two of samples 8, 9 and 10 (4, 5 and 6 in double speed) are low. Otherwise it is dropped and the receiver waits for a new falling edge.
- R5: Each data, parity and stop bit takes the majority value of its three centre samples, so a single corrupted sample does not change the received value.
- R6: With parity_en_i=1, a parity bit follows the data bits. parity_odd_i=0 selects even parity and 1 selects odd. The entry's parity error flag is 1 when the received bit differs from the XOR of the data bits XOR parity_odd_i.
- R7: A character ends at its first stop bit and is readable before that stop bit ends. Its frame error flag is 1 when the stop bit voted 0. A second stop bit is not examined.
- R8: Two characters are queued. rx_valid_o is 1 while any are unread. rd_data_o, frame_err_o and parity_err_o show the oldest one. A one-cycle rd_i pops it, and the next entry appears one cycle later.
- R9: A third character completed while the queue is full is held, and enters the queue once a read frees a slot.
- R10: overrun_o is set when a start bit is accepted while the queue is full and a character is held. The held character is discarded. overrun_o stays set until a read or until the receiver is disabled.
- R11: rx_en_i=0 empties the queue, clears overrun_o and the held character, and idles the receiver. Frames sent while it is 0 are not stored.
- R12: irq_o is 1 exactly when rx_valid_o and irq_en_i are both 1.
- R13: Frames whose bit period differs from nominal by 2.5 percent in either direction are received without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable; low flushes the queue |
| sample_en_i | input | 1 | One-cycle sample-rate pulse |
| dbl_speed_i | input | 1 | 1 = 8 samples per bit, 0 = 16 |
| data_len_i | input | 4 | Data bits per character (5..9) |
| parity_en_i | input | 1 | Parity bit present |
| parity_odd_i | input | 1 | 1 = odd parity, 0 = even |
| irq_en_i | input | 1 | Interrupt enable |
| rx_i | input | 1 | Serial line, idles high |
| rd_i | input | 1 | Pop the oldest character |
| rd_data_o | output | 9 | Oldest character |
| rx_valid_o | output | 1 | Unread data present |
| frame_err_o | output | 1 | Oldest character had a low stop bit |
| parity_err_o | output | 1 | Oldest character failed parity |
| overrun_o | output | 1 | A character was lost |
| irq_o | output | 1 | Receive interrupt |

## Verification
A wrong sample count or vote position shows up in the first frame as a shifted or corrupted character, or as a missing rx_valid_o one bit time after the stop bit. The bit-rate mismatch tests expose it faster, because the centre window drifts toward a bit edge. A wrong queue index or a misplaced held entry shows up at the first read after two or three back-to-back frames, as a character returned out of order or with another entry's flags. Overrun misbehaviour is visible as soon as the fourth frame's start bit is accepted.

// File: rtl/uart_ovs_rx_pkg.sv
package uart_ovs_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction
endpackage

// File: rtl/uart_ovs_rx_sync.sv
module uart_ovs_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_ovs_rx_frame.sv
module uart_ovs_rx_frame
  import uart_ovs_rx_pkg::*;
#(
  parameter int MAX_DW = 9,
  parameter int MIN_DW = 5,
  parameter int OVS_N  = 16,
  parameter int OVS_D  = 8,
  localparam int LW    = $clog2(MAX_DW + 1),
  localparam int SW    = $clog2(OVS_N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              dbl_i,
  input  logic              rx_i,
  input  logic [LW-1:0]     len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              start_ok_o,
  output logic              done_o,
  output logic [MAX_DW-1:0] data_o,
  output logic              fe_o,
  output logic              pe_o
);
  rx_state_e         state_q;
  logic [SW-1:0]     smp_q;
  logic [LW-1:0]     idx_q;
  logic [2:0]        vote_q;
  logic              line_hi_q;
  logic              pbit_q;
  logic [MAX_DW-1:0] data_q;

  logic [SW-1:0] per_bit, mid, cur;
  logic [LW-1:0] len_c;
  logic [2:0]    votes;
  logic          bit_v, in_win, decide;

  assign per_bit = dbl_i ? SW'(OVS_D) : SW'(OVS_N);
  assign mid     = (per_bit >> 1) + SW'(1);
  assign cur     = (smp_q == per_bit) ? SW'(1) : smp_q + SW'(1);
  assign in_win  = (cur == mid - SW'(1)) || (cur == mid) || (cur == mid + SW'(1));
  assign decide  = (cur == mid + SW'(1));
  assign votes   = {vote_q[1:0], rx_i};
  assign bit_v   = maj3(votes);

  always_comb begin
    if (len_i < LW'(MIN_DW))      len_c = LW'(MIN_DW);
    else if (len_i > LW'(MAX_DW)) len_c = LW'(MAX_DW);
    else                          len_c = len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      smp_q      <= '0;
      idx_q      <= '0;
      vote_q     <= '0;
      line_hi_q  <= 1'b0;
      pbit_q     <= 1'b0;
      data_q     <= '0;
      start_ok_o <= 1'b0;
      done_o     <= 1'b0;
      data_o     <= '0;
      fe_o       <= 1'b0;
      pe_o       <= 1'b0;
    end else begin
      start_ok_o <= 1'b0;
      done_o     <= 1'b0;
      if (!en_i) begin
        state_q   <= ST_IDLE;
        line_hi_q <= 1'b0;
      end else if (tick_i) begin
        if (state_q == ST_IDLE) begin
          line_hi_q <= rx_i;
          if (line_hi_q && !rx_i) begin
            state_q <= ST_START;
            smp_q   <= SW'(1);
            data_q  <= '0;
            idx_q   <= '0;
          end
        end else begin
          smp_q <= cur;
          if (in_win) vote_q <= votes;
          if (decide) begin
            unique case (state_q)
              ST_START: begin
                if (bit_v) begin
                  state_q   <= ST_IDLE;
                  line_hi_q <= rx_i;
                end else begin
                  state_q    <= ST_DATA;
                  start_ok_o <= 1'b1;
                end
              end
              ST_DATA: begin
                data_q[idx_q] <= bit_v;
                if (idx_q == len_c - LW'(1)) state_q <= par_en_i ? ST_PAR : ST_STOP;
                else                         idx_q   <= idx_q + LW'(1);
              end
              ST_PAR: begin
                pbit_q  <= bit_v;
                state_q <= ST_STOP;
              end
              ST_STOP: begin
                state_q   <= ST_IDLE;
                line_hi_q <= rx_i;
                done_o    <= 1'b1;
                data_o    <= data_q;
                fe_o      <= !bit_v;
                pe_o      <= par_en_i && ((^data_q ^ par_odd_i) != pbit_q);
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_ovs_rx_buf.sv
module uart_ovs_rx_buf #(
  parameter int DW    = 9,
  parameter int DEPTH = 2,
  localparam int EW   = DW + 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          push_fe_i,
  input  logic          push_pe_i,
  input  logic          start_ok_i,
  input  logic          rd_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          fe_o,
  output logic          pe_o,
  output logic          ovr_o
);
  logic [EW-1:0] ent_q [DEPTH];
  logic [EW-1:0] ent_n [DEPTH];
  logic [EW-1:0] hold_q, hold_n;
  logic          hold_v_q, hold_v_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          ovr_q, ovr_n;
  logic          pop;

  assign pop = rd_i && (cnt_q != '0);

  always_comb begin
    ent_n    = ent_q;
    hold_n   = hold_q;
    hold_v_n = hold_v_q;
    cnt_n    = cnt_q;
    ovr_n    = ovr_q;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) ent_n[i] = ent_q[i+1];
      cnt_n = cnt_q - CW'(1);
      ovr_n = 1'b0;
    end
    // held character is older than any new one
    if (hold_v_n && cnt_n < CW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++) if (i == int'(cnt_n)) ent_n[i] = hold_q;
      cnt_n    = cnt_n + CW'(1);
      hold_v_n = 1'b0;
    end
    if (start_ok_i && hold_v_n) begin
      ovr_n    = 1'b1;
      hold_v_n = 1'b0;
    end
    if (push_i) begin
      if (cnt_n < CW'(DEPTH)) begin
        for (int i = 0; i < DEPTH; i++)
          if (i == int'(cnt_n)) ent_n[i] = {push_pe_i, push_fe_i, push_data_i};
        cnt_n = cnt_n + CW'(1);
      end else begin
        hold_n   = {push_pe_i, push_fe_i, push_data_i};
        hold_v_n = 1'b1;
      end
    end
    if (!en_i) begin
      cnt_n    = '0;
      hold_v_n = 1'b0;
      ovr_n    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      hold_q   <= '0;
      hold_v_q <= 1'b0;
      cnt_q    <= '0;
      ovr_q    <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_n[i];
      hold_q   <= hold_n;
      hold_v_q <= hold_v_n;
      cnt_q    <= cnt_n;
      ovr_q    <= ovr_n;
    end
  end

  assign valid_o = (cnt_q != '0);
  assign data_o  = ent_q[0][DW-1:0];
  assign fe_o    = ent_q[0][DW];
  assign pe_o    = ent_q[0][DW+1];
  assign ovr_o   = ovr_q;
endmodule

// File: rtl/uart_ovs_rx.sv
module uart_ovs_rx #(
  parameter int MAX_DW  = 9,
  parameter int DEPTH   = 2,
  parameter int OVS_N   = 16,
  parameter int OVS_D   = 8,
  parameter int SYNC_ST = 2,
  localparam int LW     = $clog2(MAX_DW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              sample_en_i,
  input  logic              dbl_speed_i,
  input  logic [LW-1:0]     data_len_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic              irq_en_i,
  input  logic              rx_i,
  input  logic              rd_i,
  output logic [MAX_DW-1:0] rd_data_o,
  output logic              rx_valid_o,
  output logic              frame_err_o,
  output logic              parity_err_o,
  output logic              overrun_o,
  output logic              irq_o
);
  logic              rx_s;
  logic              start_ok, done, fe, pe;
  logic [MAX_DW-1:0] fr_data;

  uart_ovs_rx_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_ovs_rx_frame #(
    .MAX_DW(MAX_DW), .OVS_N(OVS_N), .OVS_D(OVS_D)
  ) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (rx_en_i),
    .tick_i    (sample_en_i),
    .dbl_i     (dbl_speed_i),
    .rx_i      (rx_s),
    .len_i     (data_len_i),
    .par_en_i  (parity_en_i),
    .par_odd_i (parity_odd_i),
    .start_ok_o(start_ok),
    .done_o    (done),
    .data_o    (fr_data),
    .fe_o      (fe),
    .pe_o      (pe)
  );

  uart_ovs_rx_buf #(.DW(MAX_DW), .DEPTH(DEPTH)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (rx_en_i),
    .push_i     (done),
    .push_data_i(fr_data),
    .push_fe_i  (fe),
    .push_pe_i  (pe),
    .start_ok_i (start_ok),
    .rd_i       (rd_i),
    .valid_o    (rx_valid_o),
    .data_o     (rd_data_o),
    .fe_o       (frame_err_o),
    .pe_o       (parity_err_o),
    .ovr_o      (overrun_o)
  );

  assign irq_o = rx_valid_o & irq_en_i;
endmodule

// File: rtl/uart_ovs_rx_chk.sv
module uart_ovs_rx_chk #(
  parameter int DW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_en_i,
  input logic          rd_i,
  input logic          irq_en_i,
  input logic [DW-1:0] rd_data_o,
  input logic          rx_valid_o,
  input logic          overrun_o,
  input logic          irq_o
);
  a_r11_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rx_en_i) |-> (!rx_valid_o && !overrun_o));

  a_r8_hold_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rd_i && rx_en_i) |=> rx_valid_o);

  a_r8_head_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rd_i && rx_en_i) |=> $stable(rd_data_o));

  a_r10_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !rd_i && rx_en_i) |=> overrun_o);

  a_r10_ovr_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> rx_valid_o);

  a_r10_rd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rx_valid_o) |=> !overrun_o);

  a_r12_irq_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rx_valid_o && irq_en_i));
endmodule

bind uart_ovs_rx uart_ovs_rx_chk #(.DW(MAX_DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_en_i   (rx_en_i),
  .rd_i      (rd_i),
  .irq_en_i  (irq_en_i),
  .rd_data_o (rd_data_o),
  .rx_valid_o(rx_valid_o),
  .overrun_o (overrun_o),
  .irq_o     (irq_o)
);

// File: tb/uart_ovs_rx_tb_top.sv
module uart_ovs_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 5;
  localparam int BIT_N      = 16 * TICK_DIV;
  localparam int BIT_D      = 8 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, tick = 1'b0, dbl = 1'b0;
  logic [3:0] len = 4'd8;
  logic       pen = 1'b0, podd = 1'b0, irq_en = 1'b0;
  logic       rx = 1'b1, rd = 1'b0;
  logic [8:0] rd_data;
  logic       valid, fe, pe, ovr, irq;
  logic [2:0] tdiv = '0;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    tdiv <= (tdiv == 3'(TICK_DIV - 1)) ? 3'd0 : tdiv + 3'd1;
    tick <= (tdiv == 3'd0);
  end

  uart_ovs_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .sample_en_i(tick),
    .dbl_speed_i(dbl), .data_len_i(len), .parity_en_i(pen),
    .parity_odd_i(podd), .irq_en_i(irq_en), .rx_i(rx), .rd_i(rd),
    .rd_data_o(rd_data), .rx_valid_o(valid), .frame_err_o(fe),
    .parity_err_o(pe), .overrun_o(ovr), .irq_o(irq)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic put(input logic b, input int n);
    rx = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int bc, input bit bad_par,
                      input bit stop_v, input int gbit, input bit early);
    int       n;
    logic [8:0] m;
    n = (len < 5) ? 5 : ((len > 9) ? 9 : int'(len));
    m = 9'((10'd1 << n) - 10'd1);
    put(1'b0, bc);
    for (int i = 0; i < n; i++) begin
      if (i == gbit) begin
        put(d[i], bc/2 - 2);
        put(!d[i], 4);
        put(d[i], bc - bc/2 - 2);
      end else put(d[i], bc);
    end
    if (pen) put((^(d & m)) ^ podd ^ bad_par, bc);
    if (early) begin
      put(stop_v, 70);
      chk("R7 ready in stop bit", valid, 1);
      put(stop_v, bc - 70);
    end else put(stop_v, bc);
    put(1'b1, bc);
  endtask

  task automatic pop_chk(input string r, input logic [8:0] d, input logic e_fe, input logic e_pe);
    chk({r, " valid"}, valid, 1);
    chk({r, " data"}, rd_data, d);
    chk({r, " fe"}, fe, e_fe);
    chk({r, " pe"}, pe, e_pe);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 valid", valid, 0);
    chk("R1 ovr", ovr, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_basic;
    len = 8; pen = 0;
    send(9'h0A5, BIT_N, 0, 1, -1, 0);
    pop_chk("R2 8N1", 9'h0A5, 0, 0);
    chk("R8 empty after pop", valid, 0);
  endtask

  task automatic t_len;
    len = 5;
    send(9'h015, BIT_N, 0, 1, -1, 0);
    pop_chk("R2 5 bits", 9'h015, 0, 0);
    len = 2;
    send(9'h00B, BIT_N, 0, 1, -1, 0);
    pop_chk("R2 clamp low", 9'h00B, 0, 0);
    len = 8;
  endtask

  task automatic t_parity;
    len = 9; pen = 1; podd = 0;
    send(9'h1C3, BIT_N, 0, 1, -1, 0);
    pop_chk("R6 even ok", 9'h1C3, 0, 0);
    podd = 1;
    send(9'h0F1, BIT_N, 1, 1, -1, 0);
    pop_chk("R6 odd bad", 9'h0F1, 0, 1);
    len = 8; pen = 0; podd = 0;
  endtask

  task automatic t_stop;
    send(9'h03C, BIT_N, 0, 0, -1, 0);
    pop_chk("R7 frame err", 9'h03C, 1, 0);
    send(9'h081, BIT_N, 0, 1, -1, 1);
    pop_chk("R7 after early", 9'h081, 0, 0);
  endtask

  task automatic t_glitch;
    put(1'b0, 10);
    put(1'b1, 3 * BIT_N);
    chk("R4 spike rejected", valid, 0);
    send(9'h05A, BIT_N, 0, 1, 3, 0);
    pop_chk("R5 glitch bit3", 9'h05A, 0, 0);
    send(9'h0C6, BIT_N, 0, 1, 6, 0);
    pop_chk("R5 glitch bit6", 9'h0C6, 0, 0);
  endtask

  task automatic t_rate;
    send(9'h0E7, BIT_N - 2, 0, 1, -1, 0);
    pop_chk("R13 fast", 9'h0E7, 0, 0);
    send(9'h019, BIT_N + 2, 0, 1, -1, 0);
    pop_chk("R13 slow", 9'h019, 0, 0);
  endtask

  task automatic t_dbl;
    dbl = 1;
    send(9'h06D, BIT_D, 0, 1, -1, 0);
    pop_chk("R3 double speed", 9'h06D, 0, 0);
    put(1'b0, 8);
    put(1'b1, 3 * BIT_D);
    chk("R4 spike dbl", valid, 0);
    dbl = 0;
  endtask

  task automatic t_queue;
    pen = 1; podd = 0;
    send(9'h011, BIT_N, 1, 1, -1, 0);
    send(9'h022, BIT_N, 0, 1, -1, 0);
    pop_chk("R8 oldest flags", 9'h011, 0, 1);
    pop_chk("R8 second flags", 9'h022, 0, 0);
    chk("R8 empty", valid, 0);
    pen = 0;
  endtask

  task automatic t_hold;
    send(9'h031, BIT_N, 0, 1, -1, 0);
    send(9'h032, BIT_N, 0, 1, -1, 0);
    send(9'h033, BIT_N, 0, 1, -1, 0);
    chk("R9 no overrun", ovr, 0);
    pop_chk("R9 first", 9'h031, 0, 0);
    pop_chk("R9 second", 9'h032, 0, 0);
    pop_chk("R9 held", 9'h033, 0, 0);
    chk("R9 empty", valid, 0);
  endtask

  task automatic t_overrun;
    send(9'h041, BIT_N, 0, 1, -1, 0);
    send(9'h042, BIT_N, 0, 1, -1, 0);
    send(9'h043, BIT_N, 0, 1, -1, 0);
    send(9'h044, BIT_N, 0, 1, -1, 0);
    chk("R10 overrun set", ovr, 1);
    pop_chk("R10 first", 9'h041, 0, 0);
    chk("R10 cleared by read", ovr, 0);
    pop_chk("R10 second", 9'h042, 0, 0);
    pop_chk("R10 newest kept", 9'h044, 0, 0);
    chk("R10 empty", valid, 0);
  endtask

  task automatic t_irq;
    send(9'h055, BIT_N, 0, 1, -1, 0);
    chk("R12 irq off", irq, 0);
    irq_en = 1; @(negedge clk);
    chk("R12 irq on", irq, 1);
    pop_chk("R12 data", 9'h055, 0, 0);
    chk("R12 irq after pop", irq, 0);
    irq_en = 0;
  endtask

  task automatic t_disable;
    send(9'h066, BIT_N, 0, 1, -1, 0);
    rx_en = 0; @(negedge clk); @(negedge clk);
    chk("R11 flushed", valid, 0);
    send(9'h077, BIT_N, 0, 1, -1, 0);
    chk("R11 ignored while off", valid, 0);
    rx_en = 1; @(negedge clk);
    chk("R11 still empty", valid, 0);
    send(9'h088, BIT_N, 0, 1, -1, 0);
    pop_chk("R11 resumes", 9'h088, 0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    put(1'b1, BIT_N);
    t_basic();
    t_len();
    t_parity();
    t_stop();
    t_glitch();
    t_rate();
    t_dbl();
    t_queue();
    t_hold();
    t_overrun();
    t_irq();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule